// File: doc/BRIEF.md
# Retriggerable Gated One-Shot Pulse Generator

This block is a clocked, counter-driven one-shot. It produces a single output pulse of a programmable number of clock cycles. The pulse starts when a qualified edge appears on one of its gated inputs. There are two gate/trigger inputs, one active-low and one active-high, and an active-low clear. A trigger fires in any of three situations:

- the high gate rises while the low gate is held low;
- the low gate falls while the high gate is held high;
- the clear is released while both gates are already in their enabling levels.

A qualified trigger that arrives while a pulse is running reloads the full length. Back-to-back triggers can therefore keep the output high without a gap.

All inputs are expected to be synchronous to the clock and free of bounce. Edges are found by comparing each input with a registered copy of its previous level. Triggering therefore depends only on a level change between two clock samples, and not on how slowly the input moves. The pulse length is read from a parallel input at the moment of each trigger. Holding clear low ends any pulse and blocks every trigger. The two outputs are complementary registers. Both come out of reset in the idle state.

Top module: `osp_retrig_oneshot`

## Requirements
- R1: While reset is asserted and directly after it, `pulse_q` is 0 and `pulse_q_n` is 1.
- R2: With `trig_lo_n` at 0, `clear_n` at 1 and `trig_hi` going from 0 to 1 between two clock samples, a pulse starts.
- R3: With `trig_hi` at 1, `clear_n` at 1 and `trig_lo_n` going from 1 to 0 between two clock samples, a pulse starts.
- R4: With `trig_lo_n` at 0 and `trig_hi` at 1, `clear_n` going from 0 to 1 between two clock samples starts a pulse.
- R5: A clock edge that samples `clear_n` at 0 drives `pulse_q` to 0 and discards any remaining count. While `clear_n` is 0, no trigger is accepted.
- R6: When no further trigger arrives, `pulse_q` goes high on the first clock edge after the trigger is sampled and stays high for exactly `pulse_len` cycles.
- R7: A qualified trigger during an active pulse reloads the count from `pulse_len`, so the pulse lasts `pulse_len` cycles from the latest trigger.
- R8: A trigger sampled with `pulse_len` equal to 0 starts no pulse and leaves a running pulse unchanged.
- R9: `pulse_q_n` is the inverse of `pulse_q` on every cycle.
- R10: No pulse starts from a level that is merely held, from a rising `trig_hi` while `trig_lo_n` is 1, or from a falling `trig_lo_n` while `trig_hi` is 0. The edge registers reset to levels that cannot produce an edge on the first cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_lo_n | input | 1 | Active-low gate/trigger input (fires on a falling edge) |
| trig_hi | input | 1 | Active-high gate/trigger input (fires on a rising edge) |
| clear_n | input | 1 | Active-low clear. Its release can also trigger |
| pulse_len | input | LEN_W | Pulse length in clock cycles, sampled at each trigger |
| pulse_q | output | 1 | Pulse output, high while active |
| pulse_q_n | output | 1 | Complement of `pulse_q` |

## Verification
On every cycle the checker confirms four things:

- the outputs are complementary;
- a clear sampled low leaves the output low;
- every rise of the output is preceded by a qualified trigger;
- the counter reloads on a trigger with a nonzero length and otherwise counts down by one.

Only the bench's scenarios can show the rest. It covers which combinations of old and new input levels qualify as a trigger, the exact pulse width for each length, and long retrigger runs that hold the output high. It also covers the idle state after reset and zero-length triggers arriving in the middle of a pulse.

// File: rtl/osp_pkg.sv
package osp_pkg;

   typedef enum logic {
      EDGE_RISE = 1'b0,
      EDGE_FALL = 1'b1
   } edge_kind_e;

   typedef struct packed {
      logic lo_fall;
      logic hi_rise;
      logic clr_rise;
   } edge_set_t;

   localparam int MAX_LEN_W = 32;

endpackage

// File: rtl/osp_edge_det.sv
module osp_edge_det #(
   parameter osp_pkg::edge_kind_e KIND = osp_pkg::EDGE_RISE
) (
   input  logic clk,
   input  logic rst_n,
   input  logic level_i,
   output logic edge_o
);
   // Reset level is chosen so the first sample after reset cannot form an edge.
   localparam logic RST_LEVEL = (KIND == osp_pkg::EDGE_RISE) ? 1'b1 : 1'b0;

   logic prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= RST_LEVEL;
      else        prev_q <= level_i;
   end

   generate
      if (KIND == osp_pkg::EDGE_RISE) begin : g_rise
         assign edge_o = level_i & ~prev_q;
      end else begin : g_fall
         assign edge_o = ~level_i & prev_q;
      end
   endgenerate

endmodule

// File: rtl/osp_trig_qual.sv
module osp_trig_qual (
   input  logic               lo_n_i,
   input  logic               hi_i,
   input  logic               clear_n_i,
   input  osp_pkg::edge_set_t edges_i,
   output logic               fire_o
);
   logic gate_open;
   logic any_edge;

   // Both gates must sit at their enabling levels once the edge is seen.
   assign gate_open = ~lo_n_i & hi_i;
   assign any_edge  = edges_i.lo_fall | edges_i.hi_rise | edges_i.clr_rise;
   assign fire_o    = clear_n_i & gate_open & any_edge;

endmodule

// File: rtl/osp_pulse_cnt.sv
module osp_pulse_cnt #(
   parameter int LEN_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear_n_i,
   input  logic             fire_i,
   input  logic [LEN_W-1:0] len_i,
   output logic [LEN_W-1:0] cnt_o,
   output logic             q_o,
   output logic             q_n_o
);
   localparam logic [LEN_W-1:0] ZERO = '0;
   localparam logic [LEN_W-1:0] ONE  = LEN_W'(1);

   logic [LEN_W-1:0] cnt_q;
   logic [LEN_W-1:0] cnt_nx;
   logic             load;

   assign load = fire_i & (len_i != ZERO);

   always_comb begin
      if (!clear_n_i)         cnt_nx = ZERO;
      else if (load)          cnt_nx = len_i;
      else if (cnt_q != ZERO) cnt_nx = cnt_q - ONE;
      else                    cnt_nx = cnt_q;
   end

   // Both outputs are taken from the next count, so they change on the same edge.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= ZERO;
         q_o   <= 1'b0;
         q_n_o <= 1'b1;
      end else begin
         cnt_q <= cnt_nx;
         q_o   <= (cnt_nx != ZERO);
         q_n_o <= (cnt_nx == ZERO);
      end
   end

   assign cnt_o = cnt_q;

endmodule

// File: rtl/osp_retrig_oneshot.sv
module osp_retrig_oneshot #(
   parameter int LEN_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             trig_lo_n,
   input  logic             trig_hi,
   input  logic             clear_n,
   input  logic [LEN_W-1:0] pulse_len,
   output logic             pulse_q,
   output logic             pulse_q_n
);
   generate
      if (LEN_W < 1 || LEN_W > osp_pkg::MAX_LEN_W) begin : g_bad_len_w
         $error("osp_retrig_oneshot: LEN_W out of range");
      end
   endgenerate

   osp_pkg::edge_set_t edges;
   logic               fire;
   logic [LEN_W-1:0]   cnt_q;

   osp_edge_det #(.KIND(osp_pkg::EDGE_FALL)) u_lo_edge (
      .clk(clk), .rst_n(rst_n), .level_i(trig_lo_n), .edge_o(edges.lo_fall)
   );

   osp_edge_det #(.KIND(osp_pkg::EDGE_RISE)) u_hi_edge (
      .clk(clk), .rst_n(rst_n), .level_i(trig_hi), .edge_o(edges.hi_rise)
   );

   osp_edge_det #(.KIND(osp_pkg::EDGE_RISE)) u_clr_edge (
      .clk(clk), .rst_n(rst_n), .level_i(clear_n), .edge_o(edges.clr_rise)
   );

   osp_trig_qual u_qual (
      .lo_n_i   (trig_lo_n),
      .hi_i     (trig_hi),
      .clear_n_i(clear_n),
      .edges_i  (edges),
      .fire_o   (fire)
   );

   osp_pulse_cnt #(.LEN_W(LEN_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear_n_i(clear_n),
      .fire_i   (fire),
      .len_i    (pulse_len),
      .cnt_o    (cnt_q),
      .q_o      (pulse_q),
      .q_n_o    (pulse_q_n)
   );

endmodule

// File: rtl/osp_retrig_oneshot_chk.sv
module osp_retrig_oneshot_chk #(
   parameter int LEN_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             clear_n,
   input logic [LEN_W-1:0] pulse_len,
   input logic             pulse_q,
   input logic             pulse_q_n,
   input logic             fire,
   input logic [LEN_W-1:0] cnt_q
);

   // R9
   a_r9_complement: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_q_n == !pulse_q);

   // R5
   a_r5_clear_ends: assert property (@(posedge clk) disable iff (!rst_n)
      !clear_n |=> !pulse_q);

   // R2 / R6: a trigger with a nonzero length raises the output next cycle
   a_r6_fire_starts: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && pulse_len != '0) |=> pulse_q);

   // R10: no rise of the output without a qualified trigger
   a_r10_no_spont: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pulse_q) |-> $past(fire));

   // R7
   a_r7_reload: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && pulse_len != '0) |=> cnt_q == $past(pulse_len));

   // R8
   a_r8_zero_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && pulse_len == '0 && !pulse_q && clear_n) |=> !pulse_q);

   // R6: countdown by one with no trigger or clear
   a_r6_countdown: assert property (@(posedge clk) disable iff (!rst_n)
      (pulse_q && clear_n && !(fire && pulse_len != '0))
      |=> cnt_q == LEN_W'($past(cnt_q) - 1'b1));

endmodule

bind osp_retrig_oneshot osp_retrig_oneshot_chk #(.LEN_W(LEN_W)) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .clear_n  (clear_n),
   .pulse_len(pulse_len),
   .pulse_q  (pulse_q),
   .pulse_q_n(pulse_q_n),
   .fire     (fire),
   .cnt_q    (cnt_q)
);

// File: tb/osp_retrig_oneshot_tb_top.sv
`timescale 1ns/1ps
module osp_retrig_oneshot_tb_top;
   localparam int LW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          lo_n = 1'b1;
   logic          hi = 1'b0;
   logic          clr_n = 1'b1;
   logic [LW-1:0] len = '0;
   logic          q, qn;

   always #2.5 clk = ~clk;

   osp_retrig_oneshot #(.LEN_W(LW)) dut_i (
      .clk(clk), .rst_n(rst_n), .trig_lo_n(lo_n), .trig_hi(hi),
      .clear_n(clr_n), .pulse_len(len), .pulse_q(q), .pulse_q_n(qn)
   );

   int vectors = 0;
   int fails = 0;
   bit done = 0;

   // Reference model state
   bit pa = 1'b0, pb = 1'b1, pc = 1'b1;
   int rem = 0;
   int hi_count = 0;

   task automatic check_bit(string tag, logic act, logic exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
      end
   endtask

   task automatic check_int(string tag, int act, int exp);
      vectors++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic step(bit a, bit b, bit c, int l);
      bit trig;
      string tag;
      lo_n = a; hi = b; clr_n = c; len = l[LW-1:0];
      @(posedge clk);
      trig = c && !a && b && (!pb || pa || !pc);
      if (!rst_n) begin
         rem = 0; tag = "R1";
      end else if (!c) begin
         rem = 0; tag = "R5";
      end else if (trig && l != 0) begin
         if (rem != 0)  tag = "R7";
         else if (!pb)  tag = "R2";
         else if (pa)   tag = "R3";
         else           tag = "R4";
         rem = l;
      end else begin
         tag = trig ? "R8" : (rem != 0 ? "R6" : "R10");
         if (rem != 0) rem--;
      end
      if (!rst_n) begin pa = 1'b0; pb = 1'b1; pc = 1'b1; end
      else begin pa = a; pb = b; pc = c; end
      @(negedge clk);
      check_bit(tag, q, rem != 0);
      check_bit("R9", qn, rem == 0);
      if (q === 1'b1) hi_count++;
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) step(1'b1, 1'b0, 1'b1, 0);
   endtask

   initial begin
      // R1: reset state
      rst_n = 1'b0;
      step(1'b0, 1'b1, 1'b1, 5);
      step(1'b1, 1'b0, 1'b0, 5);
      check_bit("R1", q, 1'b0);
      check_bit("R1", qn, 1'b1);
      // Release reset with gates enabling: no false edge (R10)
      step(1'b0, 1'b1, 1'b1, 5);
      rst_n = 1'b1;
      step(1'b0, 1'b1, 1'b1, 5);
      check_bit("R10", q, 1'b0);
      idle(3);

      // R6: exact width for every length
      for (int l = 1; l < (1 << LW); l++) begin
         idle(2);
         hi_count = 0;
         step(1'b0, 1'b1, 1'b1, l);
         for (int k = 0; k < 20; k++) step(1'b0, 1'b1, 1'b1, 0);
         check_int("R6", hi_count, l);
      end

      // R7: retrigger every 3 cycles with length 4 keeps output high
      idle(2);
      step(1'b1, 1'b1, 1'b1, 4);
      hi_count = 0;
      for (int k = 0; k < 10; k++) begin
         step(1'b0, 1'b1, 1'b1, 4);
         step(1'b0, 1'b1, 1'b1, 4);
         step(1'b1, 1'b1, 1'b1, 4);
      end
      check_int("R7", hi_count, 30);
      idle(6);

      // R8: zero-length trigger mid-pulse leaves pulse unchanged
      step(1'b0, 1'b0, 1'b1, 0);
      step(1'b0, 1'b1, 1'b1, 6);
      step(1'b1, 1'b1, 1'b1, 0);
      step(1'b0, 1'b1, 1'b1, 0);
      step(1'b0, 1'b1, 1'b1, 0);
      idle(8);

      // Exhaustive two-step sweep of input level pairs and lengths
      for (int p = 0; p < 8; p++)
         for (int n = 0; n < 8; n++)
            for (int li = 0; li < 3; li++) begin
               int l;
               l = (li == 0) ? 0 : (li == 1 ? 2 : 5);
               step(p[0], p[1], p[2], l);
               step(n[0], n[1], n[2], l);
               idle(6);
            end

      // Random walk with mixed lengths
      for (int k = 0; k < 3000; k++)
         step($urandom_range(0, 1), $urandom_range(0, 1),
              ($urandom_range(0, 7) != 0), $urandom_range(0, (1 << LW) - 1));

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      #900000;
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

endmodule